// File: doc/BRIEF.md
# Single-Precision Compare Condition Unit

This block compares two single-precision IEEE-754 operands and produces a 2-bit condition code. The code is merged into a copy of a 32-bit floating-point status word, where it lands in bits 11:10. A caller raises `start_i` for a cycle with the operands, the compare mode and the current status word. One clock later the unit pulses `done_o` and presents the code, the merged status and an invalid-operation flag. That flag is intended for a downstream exception recorder.

Two compare modes exist. The quiet mode raises invalid only when the result is unordered and at least one operand is a signaling NaN. The signaling mode raises invalid on every unordered result. When invalid is raised and the invalid trap is enabled, the result is inhibited: the status word passes through with its old condition bits.

Top module: `fcmp_cond_unit`

## Requirements
- R1: On completion, `status_o` equals `status_i` captured at start with bits 11:10 replaced by the condition code; all other bits are copied unchanged. Only one condition field exists.
- R2: The condition code encoding is 0 = equal, 1 = src1 below src2, 2 = src1 above src2, 3 = unordered. `cc_o` carries this code on completion.
- R3: Positive zero and negative zero compare as equal (code 0).
- R4: An operand is a NaN when its exponent bits 30:23 are all ones and its fraction bits 22:0 are non-zero. It is signaling when fraction bit 22 is 0. A compare with any NaN operand gives code 3.
- R5: With `signaling_i` = 1, `invalid_o` is 1 exactly when the code is 3.
- R6: With `signaling_i` = 0, `invalid_o` is 1 exactly when the code is 3 and at least one operand is a signaling NaN.
- R7: When `invalid_o` is 1 and `inv_trap_en_i` was 1 at start, `status_o` equals `status_i` unchanged, including bits 11:10. `cc_o` still reports the computed code.
- R8: `done_o` is 1 in the cycle after each cycle with `start_i` = 1 and 0 otherwise. `cc_o`, `invalid_o` and `status_o` hold their values when no compare completes.
- R9: A synchronous active-low reset clears `done_o`, `cc_o`, `invalid_o` and `status_o` to 0.
- R10: Non-NaN operands, including infinities and denormals, are ordered by sign and magnitude. A negative value is below any positive value. For two negative values, the larger magnitude is below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Launch a compare this cycle |
| signaling_i | input | 1 | 1 = signaling compare, 0 = quiet compare |
| inv_trap_en_i | input | 1 | Invalid-operation trap enable |
| src1_i | input | 32 | First operand (single precision) |
| src2_i | input | 32 | Second operand (single precision) |
| status_i | input | 32 | Status word to merge the code into |
| done_o | output | 1 | One-cycle completion pulse |
| cc_o | output | 2 | Condition code |
| invalid_o | output | 1 | Invalid-operation flag |
| status_o | output | 32 | Status word with the condition code merged |

## Verification
All four results are registered once, so each is due in the cycle right after the `start_i` cycle. The bench drives inputs at the falling edge and lowers `start_i` at the next falling edge. It compares `done_o`, `cc_o`, `invalid_o` and `status_o` against function-computed values at that point. One further falling edge later, it confirms that `done_o` has dropped and the outputs have held. Expected ordering comes from an unsigned key built from the operand bits, an approach separate from the design's sign-magnitude path.

// File: rtl/fcmp_pkg.sv
// Package: shared widths, condition code encoding and operand class type
// for the single-precision compare unit.
package fcmp_pkg;
    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int FP_W   = 1 + EXP_W + FRAC_W;

    typedef enum logic [1:0] {
        CC_EQ    = 2'd0,
        CC_LESS  = 2'd1,
        CC_GREAT = 2'd2,
        CC_UNORD = 2'd3
    } cc_e;

    typedef struct packed {
        logic is_nan;
        logic is_snan;
        logic is_zero;
        logic sign;
    } fp_class_t;
endpackage

// File: rtl/fcmp_classify.sv
// Module: fcmp_classify
// Classifies one operand as NaN, signaling NaN or zero and extracts its sign.
// Assumes the IEEE-754 layout sign | exponent | fraction, with the fraction
// MSB marking a quiet NaN.
module fcmp_classify
    import fcmp_pkg::*;
#(
    parameter int E_W = EXP_W,
    parameter int F_W = FRAC_W,
    localparam int W  = 1 + E_W + F_W
) (
    input  logic [W-1:0] val_i,
    output fp_class_t    cls_o
);
    logic [E_W-1:0] exp_f;
    logic [F_W-1:0] frac_f;

    // Field split and class decode.
    always_comb begin
        exp_f          = val_i[W-2 -: E_W];
        frac_f         = val_i[F_W-1:0];
        cls_o.sign     = val_i[W-1];
        cls_o.is_nan   = (&exp_f) && (|frac_f);
        cls_o.is_snan  = cls_o.is_nan && !frac_f[F_W-1];
        cls_o.is_zero  = (exp_f == '0) && (frac_f == '0);
    end
endmodule

// File: rtl/fcmp_order.sv
// Module: fcmp_order
// Derives the condition code from two classified operands. NaNs give
// unordered, signed zeros are equal, and otherwise the result comes from the
// sign and a magnitude compare that is reversed when both operands are negative.
module fcmp_order
    import fcmp_pkg::*;
#(
    parameter int W = FP_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  fp_class_t    a_cls_i,
    input  fp_class_t    b_cls_i,
    output cc_e          cc_o
);
    logic [W-2:0] mag_a;
    logic [W-2:0] mag_b;
    logic         mag_lt;
    logic         mag_eq;

    // Ordering decision by priority: unordered, zeros, sign, magnitude.
    always_comb begin
        mag_a  = a_i[W-2:0];
        mag_b  = b_i[W-2:0];
        mag_lt = mag_a < mag_b;
        mag_eq = mag_a == mag_b;
        if (a_cls_i.is_nan || b_cls_i.is_nan)
            cc_o = CC_UNORD;
        else if (a_cls_i.is_zero && b_cls_i.is_zero)
            cc_o = CC_EQ;
        else if (a_cls_i.sign != b_cls_i.sign)
            cc_o = a_cls_i.sign ? CC_LESS : CC_GREAT;
        else if (mag_eq)
            cc_o = CC_EQ;
        else if (mag_lt ^ a_cls_i.sign)
            cc_o = CC_LESS;
        else
            cc_o = CC_GREAT;
    end
endmodule

// File: rtl/fcmp_cond_unit.sv
// Module: fcmp_cond_unit (top)
// Single-precision compare with a quiet or signaling mode. Registers the
// condition code, the invalid flag and a status word whose condition field is
// replaced unless a trapping invalid inhibits the result. The result is ready
// one cycle after start.
module fcmp_cond_unit
    import fcmp_pkg::*;
#(
    parameter int STAT_W = 32,
    parameter int CC_LSB = 10,
    localparam int CC_MSB = CC_LSB + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              signaling_i,
    input  logic              inv_trap_en_i,
    input  logic [FP_W-1:0]   src1_i,
    input  logic [FP_W-1:0]   src2_i,
    input  logic [STAT_W-1:0] status_i,
    output logic              done_o,
    output logic [1:0]        cc_o,
    output logic              invalid_o,
    output logic [STAT_W-1:0] status_o
);
    fp_class_t         cls [2];
    logic [FP_W-1:0]   ops [2];
    cc_e               cc_n;
    logic              inv_n;
    logic [STAT_W-1:0] stat_n;

    assign ops[0] = src1_i;
    assign ops[1] = src2_i;

    // One classifier per operand.
    for (genvar g = 0; g < 2; g++) begin : g_cls
        fcmp_classify #(.E_W(EXP_W), .F_W(FRAC_W)) cls_i (
            .val_i (ops[g]),
            .cls_o (cls[g])
        );
    end

    fcmp_order #(.W(FP_W)) ord_i (
        .a_i     (src1_i),
        .b_i     (src2_i),
        .a_cls_i (cls[0]),
        .b_cls_i (cls[1]),
        .cc_o    (cc_n)
    );

    // Invalid rule per mode, then the status merge unless inhibited.
    always_comb begin
        inv_n  = (cc_n == CC_UNORD) &&
                 (signaling_i || cls[0].is_snan || cls[1].is_snan);
        stat_n = status_i;
        if (!(inv_n && inv_trap_en_i))
            stat_n[CC_MSB:CC_LSB] = cc_n;
    end

    // Result registers, loaded only when a compare is launched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o    <= 1'b0;
            cc_o      <= 2'd0;
            invalid_o <= 1'b0;
            status_o  <= '0;
        end else begin
            done_o <= start_i;
            if (start_i) begin
                cc_o      <= cc_n;
                invalid_o <= inv_n;
                status_o  <= stat_n;
            end
        end
    end

    AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o); // R8
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> (!done_o && $stable(status_o) && $stable(cc_o))); // R8
    AST_INVALID_UNORD: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && invalid_o) |-> (cc_o == 2'd3)); // R6
    AST_SIG_UNORD: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && signaling_i |=> (invalid_o == (cc_o == 2'd3))); // R5
    AST_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && inv_trap_en_i |=> (invalid_o -> (status_o == $past(status_i)))); // R7
    AST_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (status_o[CC_LSB-1:0] == $past(status_i[CC_LSB-1:0]))); // R1
endmodule

// File: tb/fcmp_cond_unit_tb.sv
`timescale 1ns/1ps
module fcmp_cond_unit_tb_top;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        start_i = 0, signaling_i = 0, inv_trap_en_i = 0;
    logic [31:0] src1_i = 0, src2_i = 0, status_i = 0;
    logic        done_o, invalid_o;
    logic [1:0]  cc_o;
    logic [31:0] status_o;
    int checks = 0, fails = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    fcmp_cond_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .signaling_i(signaling_i),
        .inv_trap_en_i(inv_trap_en_i), .src1_i(src1_i), .src2_i(src2_i),
        .status_i(status_i), .done_o(done_o), .cc_o(cc_o),
        .invalid_o(invalid_o), .status_o(status_o)
    );

    function automatic bit is_nan(input logic [31:0] v);
        return (v[30:23] == 8'hFF) && (v[22:0] != 0);
    endfunction
    function automatic bit is_snan(input logic [31:0] v);
        return is_nan(v) && !v[22];
    endfunction
    // Monotone unsigned key: zeros collapse, negatives inverted.
    function automatic logic [31:0] key(input logic [31:0] v);
        if (v[30:0] == 0) return 32'h8000_0000;
        return v[31] ? ~v : (v | 32'h8000_0000);
    endfunction
    function automatic logic [1:0] exp_cc(input logic [31:0] a, input logic [31:0] b);
        if (is_nan(a) || is_nan(b)) return 2'd3;
        if (key(a) == key(b)) return 2'd0;
        return (key(a) < key(b)) ? 2'd1 : 2'd2;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run(input logic [31:0] a, input logic [31:0] b, input bit sig,
                       input bit ten, input logic [31:0] st, input string req);
        logic [1:0]  ecc;
        bit          einv;
        logic [31:0] est;
        ecc  = exp_cc(a, b);
        einv = (ecc == 3) && (sig || is_snan(a) || is_snan(b));
        est  = st;
        if (!(einv && ten)) est[11:10] = ecc;
        @(negedge clk);
        src1_i = a; src2_i = b; signaling_i = sig; inv_trap_en_i = ten;
        status_i = st; start_i = 1;
        @(negedge clk);
        start_i = 0;
        chk(done_o == 1, {req, " R8 done"}, done_o, 1);
        chk(cc_o == ecc, {req, " R2 cc"}, cc_o, ecc);
        chk(invalid_o == einv, {req, " invalid"}, invalid_o, einv);
        chk(status_o == est, {req, " R1 status"}, status_o, est);
        status_i = ~st; src1_i = b; src2_i = a;
        @(negedge clk);
        chk(done_o == 0 && status_o == est && cc_o == ecc, "R8 hold", status_o, est);
    endtask

    function automatic logic [31:0] rnd_op();
        logic [31:0] r = $urandom;
        case ($urandom % 6)
            0: r[30:23] = 8'hFF;
            1: r[30:23] = 8'h00;
            2: r[30:0]  = 0;
            default: ;
        endcase
        return r;
    endfunction

    initial begin
        #200000;
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(done_o == 0 && cc_o == 0 && invalid_o == 0 && status_o == 0, "R9 reset", status_o, 0);
        rst_n = 1;
        run(32'h3F80_0000, 32'h3F80_0000, 0, 0, 32'hFFFF_FFFF, "R2 eq");
        run(32'h3F80_0000, 32'h4000_0000, 0, 0, 32'h0000_0000, "R2 less");
        run(32'h4000_0000, 32'h3F80_0000, 0, 0, 32'h1234_5678, "R2 greater");
        run(32'h0000_0000, 32'h8000_0000, 1, 1, 32'h0000_0C00, "R3 zeros");
        run(32'hC000_0000, 32'hBF80_0000, 0, 0, 32'h0, "R10 both negative");
        run(32'hFF80_0000, 32'h0000_0001, 0, 0, 32'h0, "R10 -inf vs denorm");
        run(32'h0000_0001, 32'h0000_0002, 0, 0, 32'h0, "R10 denorms");
        run(32'h7FC0_0000, 32'h3F80_0000, 0, 1, 32'h0, "R4 R6 qnan quiet");
        run(32'h7FC0_0000, 32'h3F80_0000, 1, 0, 32'h0, "R4 R5 qnan signaling");
        run(32'h3F80_0000, 32'h7F80_0001, 0, 0, 32'h0, "R4 R6 snan quiet");
        run(32'h7F80_0000, 32'h7F80_0000, 1, 1, 32'h0, "R10 inf eq");
        run(32'h7FA0_0000, 32'h0, 0, 1, 32'hABCD_EF01, "R7 inhibited");
        run(32'hFFC0_0000, 32'h0, 1, 1, 32'h0000_0400, "R7 R5 inhibited");
        for (int i = 0; i < 400; i++)
            run(rnd_op(), ($urandom % 4 == 0) ? 32'h8000_0000 : rnd_op(),
                $urandom % 2, $urandom % 2, $urandom, "random");
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        chk(done_o == 0 && status_o == 0, "R9 re-reset", status_o, 0);
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule